// File: doc/BRIEF.md
# Out-of-Order Issue Scoreboard

This block is the central hazard controller for a small cluster of functional units that start in program order and finish in any order. It takes in one decoded instruction per cycle: the unit type it needs, an operation code, a destination register and two source registers. It decides whether the instruction may enter its unit now. After that it follows each unit through operand read, execution and result write. It says per unit when the operands may be read from the register file and when the result may be written back. It never forwards data: a consumer sees a producer's value only by reading the register file after the producer has written it.

Each unit holds one instruction at a time. Its entry records the operation, the destination and both sources, which unit (if any) will produce each source, and whether each source is ready to read. A table indexed by register gives the unit that will write it, with 0 meaning none; units are numbered 1 to NUM_FU. The unit type codes are 0 integer, 1 FP add, 2 FP multiply, 3 FP divide, and type k is served by unit index k. The datapath reports the end of execution with a one-cycle pulse per unit, so latency is set outside the block.

Top module: `ooo_scoreboard`

## Requirements
- R1: After reset no read or write grant is active, and an instruction for any unit type with any destination is accepted (`iss_ready` high).
- R2: `iss_ready` is low while the requested unit holds an instruction, including the cycle of its write grant, and is high again the cycle after that grant.
- R3: `iss_ready` is low while the destination equals the destination of any instruction that has not yet been granted its write, and is not held low by a pending instruction whose destination differs.
- R4: An accepted instruction whose sources have no pending producer gets a one-cycle `rd_grant` on its unit in the cycle after acceptance, and `unit_op` for that unit shows its operation code.
- R5: A source with a pending producer holds the read grant off until that producer's write grant; the read grant comes in the cycle after that write grant.
- R6: An `exec_done` pulse counts only once the unit has had its read grant. The write grant then follows in the next cycle unless a WAR hazard or a lower-index unit holds it back. Pulses that arrive before the read grant are ignored.
- R7: At most one `wr_grant` bit is high per cycle, and among units ready to write the lowest index wins; the loser is granted in a later cycle.
- R8: A finished unit is not granted its write while another unit still has to read a source equal to its destination. The grant comes in the cycle after that reader's read grant, if no other unit blocks it.
- R9: An instruction accepted in the same cycle that its source's producer is granted its write treats that source as ready and gets its read grant in the next cycle.
- R10: While `wr_grant` is high, `wr_reg` gives the destination register of the granted unit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Decoded instruction present |
| iss_unit | input | UNIT_W (2) | Unit type code the instruction needs |
| iss_op | input | OP_W (4) | Operation code |
| iss_dst | input | REG_W (5) | Destination register |
| iss_src1 | input | REG_W (5) | First source register |
| iss_src2 | input | REG_W (5) | Second source register |
| iss_ready | output | 1 | Instruction accepted this cycle if valid |
| exec_done | input | NUM_FU (4) | Per-unit end-of-execution pulse |
| rd_grant | output | NUM_FU (4) | Per-unit permission to read operands |
| wr_grant | output | NUM_FU (4) | Per-unit permission to write the result |
| wr_reg | output | REG_W (5) | Register being written under wr_grant |
| unit_op | output | NUM_FU*OP_W (16) | Operation code held by each unit |

## Verification
A wrong ready flag or producer tag inside a unit entry shows up as a read grant that is missing or early. The check lands one cycle after the producer's write grant, and a lost wake-up stalls the consumer forever. A wrong result-table entry shows up in `iss_ready` in the same cycle as the probe, either as a false WAW stall or as a missed one. Faults in the WAR comparison or in the write arbiter show up as a `wr_grant` in the wrong cycle or on the wrong unit. The directed scenarios therefore check grants on exact cycles, counted from the acceptance and done pulses that cause them.

// File: rtl/sb_pkg.sv
package sb_pkg;

   typedef enum logic [1:0] {
      ST_IDLE     = 2'd0,
      ST_WAIT_OPS = 2'd1,
      ST_EXEC     = 2'd2,
      ST_WAIT_WR  = 2'd3
   } slot_state_e;

   localparam int UNIT_INT   = 0;
   localparam int UNIT_FADD  = 1;
   localparam int UNIT_FMUL  = 2;
   localparam int UNIT_FDIV  = 3;

endpackage

// File: rtl/sb_fu_slot.sv
module sb_fu_slot
   import sb_pkg::*;
#(
   parameter int REG_W = 5,
   parameter int OP_W  = 4,
   parameter int UID_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             issue_en,
   input  logic [OP_W-1:0]  iss_op,
   input  logic [REG_W-1:0] iss_dst,
   input  logic [REG_W-1:0] iss_src1,
   input  logic [REG_W-1:0] iss_src2,
   input  logic [UID_W-1:0] iss_q1,
   input  logic [UID_W-1:0] iss_q2,
   input  logic             done_pulse,
   input  logic             wr_win,
   input  logic [UID_W-1:0] wb_uid,
   output logic             busy,
   output logic             rd_req,
   output logic             wb_req,
   output logic [OP_W-1:0]  op_o,
   output logic [REG_W-1:0] fi,
   output logic [REG_W-1:0] fj,
   output logic [REG_W-1:0] fk,
   output logic             rj,
   output logic             rk
);

   slot_state_e      state;
   logic [UID_W-1:0] qj, qk;
   logic             wake_j, wake_k;

   assign wake_j = (wb_uid != '0) && (qj == wb_uid);
   assign wake_k = (wb_uid != '0) && (qk == wb_uid);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         op_o  <= '0;
         fi    <= '0;
         fj    <= '0;
         fk    <= '0;
         qj    <= '0;
         qk    <= '0;
         rj    <= 1'b0;
         rk    <= 1'b0;
      end else begin
         unique case (state)
            ST_IDLE: begin
               if (issue_en) begin
                  state <= ST_WAIT_OPS;
                  op_o  <= iss_op;
                  fi    <= iss_dst;
                  fj    <= iss_src1;
                  fk    <= iss_src2;
                  qj    <= iss_q1;
                  qk    <= iss_q2;
                  rj    <= (iss_q1 == '0);
                  rk    <= (iss_q2 == '0);
               end
            end
            ST_WAIT_OPS: begin
               if (rj && rk) begin
                  state <= ST_EXEC;
                  rj    <= 1'b0;
                  rk    <= 1'b0;
               end else begin
                  if (wake_j) begin
                     rj <= 1'b1;
                     qj <= '0;
                  end
                  if (wake_k) begin
                     rk <= 1'b1;
                     qk <= '0;
                  end
               end
            end
            ST_EXEC: begin
               if (done_pulse) state <= ST_WAIT_WR;
            end
            ST_WAIT_WR: begin
               if (wr_win) state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign busy   = (state != ST_IDLE);
   assign rd_req = (state == ST_WAIT_OPS) && rj && rk;
   assign wb_req = (state == ST_WAIT_WR);

   // R2
   issue_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      issue_en |-> (state == ST_IDLE));

   // R4
   rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |=> !rd_req);

   // R6
   wr_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_win |-> (state == ST_WAIT_WR));

endmodule

// File: rtl/sb_reg_status.sv
module sb_reg_status #(
   parameter int REG_W = 5,
   parameter int UID_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [REG_W-1:0] rd_a,
   input  logic [REG_W-1:0] rd_b,
   input  logic [REG_W-1:0] rd_c,
   output logic [UID_W-1:0] q_a,
   output logic [UID_W-1:0] q_b,
   output logic [UID_W-1:0] q_c,
   input  logic             set_en,
   input  logic [REG_W-1:0] set_reg,
   input  logic [UID_W-1:0] set_uid,
   input  logic             clr_en,
   input  logic [REG_W-1:0] clr_reg
);

   localparam int NREG = 1 << REG_W;

   logic [UID_W-1:0] tbl [NREG];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NREG; i++) tbl[i] <= '0;
      end else begin
         if (clr_en) tbl[clr_reg] <= '0;
         if (set_en) tbl[set_reg] <= set_uid;
      end
   end

   assign q_a = tbl[rd_a];
   assign q_b = tbl[rd_b];
   assign q_c = tbl[rd_c];

   // R3
   status_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_en |-> (tbl[set_reg] == '0));

   // R10
   status_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_en |-> (tbl[clr_reg] != '0));

endmodule

// File: rtl/sb_wb_pick.sv
module sb_wb_pick #(
   parameter int N     = 4,
   parameter int IDX_W = 2
) (
   input  logic [N-1:0]     req,
   output logic [N-1:0]     gnt,
   output logic             gnt_any,
   output logic [IDX_W-1:0] gnt_idx
);

   always_comb begin
      gnt     = '0;
      gnt_any = 1'b0;
      gnt_idx = '0;
      for (int i = 0; i < N; i++) begin
         if (req[i] && !gnt_any) begin
            gnt[i]  = 1'b1;
            gnt_any = 1'b1;
            gnt_idx = IDX_W'(i);
         end
      end
   end

endmodule

// File: rtl/ooo_scoreboard.sv
module ooo_scoreboard
   import sb_pkg::*;
#(
   parameter int NUM_FU = 4,
   parameter int REG_W  = 5,
   parameter int OP_W   = 4,
   localparam int UNIT_W = (NUM_FU > 1) ? $clog2(NUM_FU) : 1,
   localparam int UID_W  = $clog2(NUM_FU + 1)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   iss_valid,
   input  logic [UNIT_W-1:0]      iss_unit,
   input  logic [OP_W-1:0]        iss_op,
   input  logic [REG_W-1:0]       iss_dst,
   input  logic [REG_W-1:0]       iss_src1,
   input  logic [REG_W-1:0]       iss_src2,
   output logic                   iss_ready,
   input  logic [NUM_FU-1:0]      exec_done,
   output logic [NUM_FU-1:0]      rd_grant,
   output logic [NUM_FU-1:0]      wr_grant,
   output logic [REG_W-1:0]       wr_reg,
   output logic [NUM_FU*OP_W-1:0] unit_op
);

   if (NUM_FU < 1) begin : g_bad_fu
      $error("NUM_FU must be at least 1");
   end
   if (REG_W < 1 || REG_W > 8) begin : g_bad_reg
      $error("REG_W must be between 1 and 8");
   end
   if (OP_W < 1) begin : g_bad_op
      $error("OP_W must be at least 1");
   end

   logic [NUM_FU-1:0] busy, rd_req, wb_req, war, issue_en;
   logic [NUM_FU-1:0] rj_a, rk_a;
   logic [REG_W-1:0]  fi_a [NUM_FU];
   logic [REG_W-1:0]  fj_a [NUM_FU];
   logic [REG_W-1:0]  fk_a [NUM_FU];

   logic [UID_W-1:0]  q_s1, q_s2, q_d, q1_adj, q2_adj, wb_uid;
   logic              gnt_any, unit_ok, accept;
   logic [UNIT_W-1:0] gnt_idx;

   // unit-code range check only when the code can exceed the unit count
   if ((1 << UNIT_W) > NUM_FU) begin : g_unit_chk
      assign unit_ok = (int'(iss_unit) < NUM_FU);
   end else begin : g_unit_all
      assign unit_ok = 1'b1;
   end

   assign iss_ready = unit_ok && !busy[iss_unit] && (q_d == '0);
   assign accept    = iss_valid && iss_ready;

   for (genvar u = 0; u < NUM_FU; u++) begin : g_issue
      assign issue_en[u] = accept && (int'(iss_unit) == u);
   end

   // a producer writing back this very cycle no longer counts as pending
   assign wb_uid = gnt_any ? (UID_W'(gnt_idx) + UID_W'(1)) : '0;
   assign q1_adj = (q_s1 == wb_uid) ? '0 : q_s1;
   assign q2_adj = (q_s2 == wb_uid) ? '0 : q_s2;

   sb_reg_status #(
      .REG_W (REG_W),
      .UID_W (UID_W)
   ) u_status (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_a    (iss_src1),
      .rd_b    (iss_src2),
      .rd_c    (iss_dst),
      .q_a     (q_s1),
      .q_b     (q_s2),
      .q_c     (q_d),
      .set_en  (accept),
      .set_reg (iss_dst),
      .set_uid (UID_W'(iss_unit) + UID_W'(1)),
      .clr_en  (gnt_any),
      .clr_reg (wr_reg)
   );

   for (genvar u = 0; u < NUM_FU; u++) begin : g_slot
      sb_fu_slot #(
         .REG_W (REG_W),
         .OP_W  (OP_W),
         .UID_W (UID_W)
      ) u_slot (
         .clk        (clk),
         .rst_n      (rst_n),
         .issue_en   (issue_en[u]),
         .iss_op     (iss_op),
         .iss_dst    (iss_dst),
         .iss_src1   (iss_src1),
         .iss_src2   (iss_src2),
         .iss_q1     (q1_adj),
         .iss_q2     (q2_adj),
         .done_pulse (exec_done[u]),
         .wr_win     (wr_grant[u]),
         .wb_uid     (wb_uid),
         .busy       (busy[u]),
         .rd_req     (rd_req[u]),
         .wb_req     (wb_req[u]),
         .op_o       (unit_op[u*OP_W +: OP_W]),
         .fi         (fi_a[u]),
         .fj         (fj_a[u]),
         .fk         (fk_a[u]),
         .rj         (rj_a[u]),
         .rk         (rk_a[u])
      );
   end

   // WAR: another busy unit still owes a read of this unit's destination
   always_comb begin
      war = '0;
      for (int u = 0; u < NUM_FU; u++) begin
         for (int x = 0; x < NUM_FU; x++) begin
            if (x != u && busy[x] &&
                ((fj_a[x] == fi_a[u] && rj_a[x]) ||
                 (fk_a[x] == fi_a[u] && rk_a[x])))
               war[u] = 1'b1;
         end
      end
   end

   sb_wb_pick #(
      .N     (NUM_FU),
      .IDX_W (UNIT_W)
   ) u_pick (
      .req     (wb_req & ~war),
      .gnt     (wr_grant),
      .gnt_any (gnt_any),
      .gnt_idx (gnt_idx)
   );

   assign rd_grant = rd_req;
   assign wr_reg   = fi_a[gnt_idx];

   // R7
   wr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(wr_grant));

   // R6
   grant_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_grant & wr_grant) == '0);

   // R2
   wr_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_grant != '0) |=> ((busy & $past(wr_grant)) == '0));

endmodule

// File: tb/ooo_scoreboard_tb.sv
module ooo_scoreboard_tb;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        iss_valid = 1'b0;
   logic [1:0]  iss_unit = '0;
   logic [3:0]  iss_op = '0;
   logic [4:0]  iss_dst = '0;
   logic [4:0]  iss_src1 = '0;
   logic [4:0]  iss_src2 = '0;
   logic        iss_ready;
   logic [3:0]  exec_done = '0;
   logic [3:0]  rd_grant, wr_grant;
   logic [4:0]  wr_reg;
   logic [15:0] unit_op;

   int n_chk  = 0;
   int n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ooo_scoreboard u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .iss_valid (iss_valid),
      .iss_unit  (iss_unit),
      .iss_op    (iss_op),
      .iss_dst   (iss_dst),
      .iss_src1  (iss_src1),
      .iss_src2  (iss_src2),
      .iss_ready (iss_ready),
      .exec_done (exec_done),
      .rd_grant  (rd_grant),
      .wr_grant  (wr_grant),
      .wr_reg    (wr_reg),
      .unit_op   (unit_op)
   );

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // start a new cycle: inputs default to idle shortly after the edge
   task automatic cyc();
      @(posedge clk);
      #1;
      iss_valid = 1'b0;
      exec_done = '0;
   endtask

   task automatic put(int unit, int dst, int s1, int s2, bit v, int op = 5);
      iss_unit  = 2'(unit);
      iss_dst   = 5'(dst);
      iss_src1  = 5'(s1);
      iss_src2  = 5'(s2);
      iss_op    = 4'(op);
      iss_valid = v;
      #1;
   endtask

   task automatic t_reset();
      put(2, 7, 1, 2, 0);
      chk("R1 ready after reset", 32'(iss_ready), 1);
      chk("R1 no read grant", 32'(rd_grant), 0);
      chk("R1 no write grant", 32'(wr_grant), 0);
   endtask

   task automatic t_basic();
      cyc(); put(0, 3, 1, 2, 1, 9);
      chk("R1 first issue accepted", 32'(iss_ready), 1);
      cyc(); exec_done = 4'b0001; #1;
      chk("R4 read grant next cycle", 32'(rd_grant), 32'b0001);
      chk("R4 unit_op shows op", 32'(unit_op[3:0]), 9);
      cyc(); #1;
      chk("R4 read grant is one pulse", 32'(rd_grant), 0);
      chk("R6 early done ignored", 32'(wr_grant), 0);
      put(0, 9, 1, 2, 0);
      chk("R2 busy unit refused", 32'(iss_ready), 0);
      exec_done = 4'b0001; #1;
      cyc(); put(0, 9, 1, 2, 0);
      chk("R6 write grant after done", 32'(wr_grant), 32'b0001);
      chk("R10 wr_reg", 32'(wr_reg), 3);
      chk("R2 refused in grant cycle", 32'(iss_ready), 0);
      cyc(); put(0, 9, 1, 2, 0);
      chk("R2 free after grant", 32'(iss_ready), 1);
      chk("R6 grant is one cycle", 32'(wr_grant), 0);
   endtask

   task automatic t_raw();
      cyc(); put(3, 4, 1, 2, 1);
      chk("R1 divide accepted", 32'(iss_ready), 1);
      cyc(); put(1, 5, 4, 6, 1);
      chk("R4 divide reads", 32'(rd_grant), 32'b1000);
      chk("R5 consumer accepted", 32'(iss_ready), 1);
      cyc(); #1;
      chk("R5 consumer waits", 32'(rd_grant), 0);
      put(2, 4, 7, 8, 0);
      chk("R3 same destination stalls", 32'(iss_ready), 0);
      put(2, 7, 4, 8, 0);
      chk("R3 other destination passes", 32'(iss_ready), 1);
      exec_done = 4'b1000; #1;
      cyc(); #1;
      chk("R6 divide writes", 32'(wr_grant), 32'b1000);
      chk("R10 wr_reg divide", 32'(wr_reg), 4);
      chk("R5 no read in producer grant cycle", 32'(rd_grant), 0);
      cyc(); #1;
      chk("R5 read after producer write", 32'(rd_grant), 32'b0010);
      cyc(); exec_done = 4'b0010; #1;
      cyc(); #1;
      chk("R6 consumer writes", 32'(wr_grant), 32'b0010);
   endtask

   task automatic t_arb();
      cyc(); put(2, 10, 1, 2, 1);
      cyc(); put(1, 11, 1, 2, 1);
      chk("R4 mul reads", 32'(rd_grant), 32'b0100);
      cyc(); #1;
      chk("R4 add reads", 32'(rd_grant), 32'b0010);
      cyc(); exec_done = 4'b0110; #1;
      cyc(); #1;
      chk("R7 lower index first", 32'(wr_grant), 32'b0010);
      chk("R10 wr_reg first", 32'(wr_reg), 11);
      cyc(); #1;
      chk("R7 loser next", 32'(wr_grant), 32'b0100);
      chk("R10 wr_reg second", 32'(wr_reg), 10);
   endtask

   task automatic t_war();
      cyc(); put(3, 20, 1, 2, 1);
      cyc(); put(1, 21, 20, 22, 1);
      cyc(); put(0, 22, 1, 2, 1);
      chk("R8 writer accepted", 32'(iss_ready), 1);
      cyc(); #1;
      chk("R5 reader still waits", 32'(rd_grant), 32'b0001);
      cyc(); exec_done = 4'b0001; #1;
      cyc(); #1;
      chk("R8 write held by WAR", 32'(wr_grant), 0);
      cyc(); #1;
      chk("R8 write still held", 32'(wr_grant), 0);
      exec_done = 4'b1000; #1;
      cyc(); #1;
      chk("R8 blocked unit skipped", 32'(wr_grant), 32'b1000);
      cyc(); #1;
      chk("R5 reader wakes", 32'(rd_grant), 32'b0010);
      chk("R8 held during read", 32'(wr_grant), 0);
      cyc(); #1;
      chk("R8 write after read", 32'(wr_grant), 32'b0001);
      chk("R10 wr_reg WAR", 32'(wr_reg), 22);
      exec_done = 4'b0010; #1;
      cyc(); #1;
      chk("R6 reader writes", 32'(wr_grant), 32'b0010);
   endtask

   task automatic t_same_cycle();
      cyc(); put(0, 12, 1, 2, 1);
      cyc(); #1;
      chk("R4 int reads", 32'(rd_grant), 32'b0001);
      cyc(); exec_done = 4'b0001; #1;
      cyc(); put(1, 13, 12, 1, 1);
      chk("R9 producer writing", 32'(wr_grant), 32'b0001);
      chk("R9 consumer accepted", 32'(iss_ready), 1);
      cyc(); #1;
      chk("R9 consumer reads next cycle", 32'(rd_grant), 32'b0010);
      cyc(); exec_done = 4'b0010; #1;
      cyc(); #1;
      chk("R6 consumer done", 32'(wr_grant), 32'b0010);
   endtask

   initial begin
      #(CLK_PERIOD * 4000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset();
      t_basic();
      t_raw();
      t_arb();
      t_war();
      t_same_cycle();
      cyc();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule